// File: doc/BRIEF.md
# Port Edge Wakeup Detector

This block watches the pins of two 8-bit general-purpose ports and tells a power controller when one of them should wake the processor. Each pin can take part in wakeup through its own enable bit. There is one enable register per port. A pin takes part only while it is configured as an input. The pin's output data latch, which an input pin does not drive onto the pad, sets which edge direction counts. A latch value of 1 arms the pin for a rising edge, and 0 arms it for a falling edge.

Pin levels are asynchronous to the block clock. Each pin passes through a synchronizer before its edge is judged. Any qualifying edge on any pin raises a single registered wakeup request for one cycle. The same edge also sets a sticky per-pin status bit, so that software can find out afterwards which pin woke the chip. Software clears a status bit by writing 1 to it. Changing a pin's enable, direction or polarity never creates a wakeup by itself.

Top module: `gpio_wake_detect`

## Requirements
- R1: While reset is held and on the first cycle after it, `wake_req` is 0 and `wake_stat` is all zero.
- R2: Bit i of `wake_en0` enables pin i (port 0), and bit i of `wake_en1` enables pin 8+i (port 1). An edge on a pin whose enable bit is 0 raises no request and sets no status.
- R3: Polarity is taken per pin from `out_latch`. A value of 1 qualifies only a 0-to-1 edge, and 0 qualifies only a 1-to-0 edge. An edge in the other direction is ignored.
- R4: A pin with `pin_is_out` = 1 (output mode) never produces a detection.
- R5: Detection is edge-triggered. A pin that stays at its active level produces exactly one detection.
- R6: A change of a pin driven before clock edge k shows on `wake_req` after clock edge k+2. `wake_req` is high for that one cycle only and equals the OR of all pins detected at that edge.
- R7: The bit of `wake_stat` for a detected pin is set at the same edge as `wake_req`. It stays set until a 1 is written to the same bit of `stat_clr`. If a set and a clear coincide, the set wins.
- R8: If a pin's enable, direction or polarity differs from its value in the previous cycle, a detection that would fall in that cycle is dropped for that pin. A configuration change on a steady pin gives no wakeup.
- R9: No detection is made during the first three clock edges after reset is released, while the synchronizer and the previous-level register fill. A pin that is high out of reset therefore gives no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 16 | Pad levels, port 1 in bits 15:8, port 0 in bits 7:0 |
| pin_is_out | input | 16 | Direction per pin, 1 = output, 0 = input |
| out_latch | input | 16 | Output latch per pin, also the edge polarity |
| wake_en0 | input | 8 | Wakeup enable for port 0 pins |
| wake_en1 | input | 8 | Wakeup enable for port 1 pins |
| stat_clr | input | 16 | Write-1-to-clear strobe for the status bits |
| wake_req | output | 1 | One-cycle wakeup request to the power controller |
| wake_stat | output | 16 | Sticky per-pin wakeup cause |

## Verification
The directed patterns cover several separate cases. One holds a pin high straight out of reset, which shows whether the fill guard works. Rising and falling edges are run against both polarities, which separates matched edges from opposite edges. An output-mode pin and a disabled port, each toggling, show whether direction and enable are honoured separately. A pin held at its active level shows whether the block reacts to edges rather than levels. A configuration flip in the exact cycle an edge arrives exercises the suppression rule. A clear written in the same cycle as a new set checks the priority of set over clear. A long run of sparse random pin flips, configuration changes and clears is then compared cycle by cycle against a reference model of the request and status.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;

  localparam int unsigned PORT_BITS  = 8;
  localparam int unsigned SYNC_DEPTH = 2;

  // per-pin configuration snapshot
  typedef struct packed {
    logic en;
    logic is_out;
    logic pol;
  } pin_cfg_t;

  // polarity 1: rising edge qualifies, 0: falling edge qualifies
  function automatic logic edge_match(input logic now_lvl,
                                      input logic old_lvl,
                                      input logic pol);
    return pol ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);
  endfunction

endpackage

// File: rtl/gpio_wake_sync.sv
module gpio_wake_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_wake_edge.sv
module gpio_wake_edge
  import gpio_wake_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         armed,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en,
  input  logic [W-1:0] is_out,
  input  logic [W-1:0] pol,
  output logic [W-1:0] hit
);

  logic     [W-1:0] prev_lvl;
  pin_cfg_t [W-1:0] cfg_now;
  pin_cfg_t [W-1:0] cfg_q;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      assign cfg_now[i] = '{en: en[i], is_out: is_out[i], pol: pol[i]};

      // previous level and configuration refresh every cycle
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_lvl[i] <= 1'b0;
          cfg_q[i]    <= '0;
        end else begin
          prev_lvl[i] <= lvl[i];
          cfg_q[i]    <= cfg_now[i];
        end
      end

      logic cfg_stable;
      assign cfg_stable = (cfg_now[i] == cfg_q[i]);

      assign hit[i] = armed & cfg_stable & cfg_now[i].en & ~cfg_now[i].is_out
                    & edge_match(lvl[i], prev_lvl[i], cfg_now[i].pol);
    end
  endgenerate

endmodule

// File: rtl/gpio_wake_status.sv
module gpio_wake_status #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_in,
  input  logic [W-1:0] clr_in,
  output logic [W-1:0] stat
);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)            stat[i] <= 1'b0;
        else if (set_in[i]) stat[i] <= 1'b1;
        else if (clr_in[i]) stat[i] <= 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_wake_detect.sv
module gpio_wake_detect #(
  parameter int unsigned PORT_W      = gpio_wake_pkg::PORT_BITS,
  parameter int unsigned SYNC_STAGES = gpio_wake_pkg::SYNC_DEPTH,
  localparam int unsigned PIN_W      = 2 * PORT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] pin_lvl,
  input  logic [PIN_W-1:0] pin_is_out,
  input  logic [PIN_W-1:0] out_latch,
  input  logic [PORT_W-1:0] wake_en0,
  input  logic [PORT_W-1:0] wake_en1,
  input  logic [PIN_W-1:0] stat_clr,
  output logic             wake_req,
  output logic [PIN_W-1:0] wake_stat
);

  localparam int unsigned FILL = SYNC_STAGES + 1;
  localparam int unsigned CW   = $clog2(FILL + 1);

  logic [PIN_W-1:0] lvl_sync;
  logic [PIN_W-1:0] en_all;
  logic [PIN_W-1:0] hit;
  logic [CW-1:0]    fill_cnt;
  logic             armed;

  assign en_all = {wake_en1, wake_en0};

  // pipeline fill guard after reset
  always_ff @(posedge clk) begin
    if (rst)                     fill_cnt <= '0;
    else if (fill_cnt != CW'(FILL)) fill_cnt <= fill_cnt + CW'(1);
  end
  assign armed = (fill_cnt == CW'(FILL));

  gpio_wake_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_lvl),
    .q   (lvl_sync)
  );

  gpio_wake_edge #(.W(PIN_W)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .armed  (armed),
    .lvl    (lvl_sync),
    .en     (en_all),
    .is_out (pin_is_out),
    .pol    (out_latch),
    .hit    (hit)
  );

  gpio_wake_status #(.W(PIN_W)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .set_in (hit),
    .clr_in (stat_clr),
    .stat   (wake_stat)
  );

  always_ff @(posedge clk) begin
    if (rst) wake_req <= 1'b0;
    else     wake_req <= |hit;
  end

endmodule

// File: rtl/gpio_wake_chk.sv
module gpio_wake_chk #(
  parameter int unsigned PORT_W = 8,
  localparam int unsigned PIN_W = 2 * PORT_W
) (
  input logic              clk,
  input logic              rst,
  input logic [PORT_W-1:0] wake_en0,
  input logic [PORT_W-1:0] wake_en1,
  input logic [PIN_W-1:0]  stat_clr,
  input logic              wake_req,
  input logic [PIN_W-1:0]  wake_stat
);

  // a request always leaves a cause behind
  p_req_has_cause_r6: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> (wake_stat != '0));

  // a newly set status bit only appears together with a request
  p_new_stat_with_req_r7: assert property (@(posedge clk) disable iff (rst)
    ((wake_stat & ~$past(wake_stat)) != '0) |-> wake_req);

  // status bits not cleared are kept
  p_stat_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (($past(wake_stat) & ~$past(stat_clr) & ~wake_stat) == '0));

  // with every enable off, no request follows
  p_all_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    (($past(wake_en0) == '0) && ($past(wake_en1) == '0)) |-> !wake_req);

  // first cycle out of reset is quiet
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wake_req && (wake_stat == '0)));

endmodule

bind gpio_wake_detect gpio_wake_chk #(.PORT_W(PORT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wake_en0  (wake_en0),
  .wake_en1  (wake_en1),
  .stat_clr  (stat_clr),
  .wake_req  (wake_req),
  .wake_stat (wake_stat)
);

// File: tb/sim_gpio_wake_detect.sv
`timescale 1ns/1ps
module sim_gpio_wake_detect;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] pin, is_out, latch, clr;
  logic [7:0]  en0, en1;
  logic        wake_req;
  logic [15:0] wake_stat;

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [15:0] h1, h2, h3;
  logic [15:0] en_q, dir_q, pol_q;
  logic [15:0] exp_stat;
  logic        exp_req;
  int          cyc;

  always #10 clk = ~clk;

  gpio_wake_detect u0 (
    .clk (clk), .rst (rst), .pin_lvl (pin), .pin_is_out (is_out),
    .out_latch (latch), .wake_en0 (en0), .wake_en1 (en1),
    .stat_clr (clr), .wake_req (wake_req), .wake_stat (wake_stat)
  );

  function automatic logic [15:0] exp_hits(input logic [15:0] nw, input logic [15:0] od,
                                           input logic [15:0] en, input logic [15:0] dir,
                                           input logic [15:0] pol, input logic [15:0] chg);
    logic [15:0] m;
    m = (pol & nw & ~od) | (~pol & ~nw & od);
    return m & en & ~dir & ~chg;
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [15:0] en_all, chg, hits;
    @(posedge clk);
    en_all = {en1, en0};
    if (rst) begin
      cyc = 0; exp_req = 1'b0; exp_stat = '0;
    end else begin
      cyc++;
      chg  = (en_all ^ en_q) | (is_out ^ dir_q) | (latch ^ pol_q);
      hits = (cyc >= 4) ? exp_hits(h2, h3, en_all, is_out, latch, chg) : '0;
      exp_req  = |hits;
      exp_stat = (exp_stat & ~clr) | hits;
    end
    h3 = h2; h2 = h1; h1 = pin;
    en_q = en_all; dir_q = is_out; pol_q = latch;
    @(negedge clk);
    check(tag, "wake_req", {15'd0, wake_req}, {15'd0, exp_req});
    check(tag, "wake_stat", wake_stat, exp_stat);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    h1 = '0; h2 = '0; h3 = '0; en_q = '0; dir_q = '0; pol_q = '0;
    exp_stat = '0; exp_req = 1'b0; cyc = 0;
    rst = 1'b1; clr = '0;
    // R9: pins high and fully armed straight through reset
    pin = 16'hFFFF; is_out = '0; latch = 16'hFFFF; en0 = 8'hFF; en1 = 8'hFF;
    @(negedge clk);
    repeat (3) step("R1");
    rst = 1'b0;
    step("R1");
    repeat (6) step("R9");

    // R3: rising edge on pin 3 with polarity 1
    pin[3] = 1'b0; repeat (4) step("R3");
    pin[3] = 1'b1; repeat (4) step("R3");
    // R3: falling edge on pin 3 with polarity 1 is ignored
    pin[3] = 1'b0; repeat (4) step("R3");
    // R3: falling edge on pin 9 with polarity 0
    latch[9] = 1'b0; repeat (2) step("R3");
    pin[9] = 1'b0; repeat (4) step("R3");
    // R7: clear both status bits
    clr = 16'h0208; step("R7"); clr = '0; step("R7");
    // R4: output-mode pin toggles
    is_out[5] = 1'b1; repeat (2) step("R4");
    pin[5] = 1'b0; repeat (3) step("R4");
    pin[5] = 1'b1; repeat (4) step("R4");
    // R2: port 1 disabled while its pins toggle
    en1 = 8'h00; repeat (2) step("R2");
    pin[15:8] = 8'h00; repeat (3) step("R2");
    pin[15:8] = 8'hFF; repeat (4) step("R2");
    en1 = 8'hFF; repeat (2) step("R2");
    // R5: pin 0 falls then stays high for a long time
    pin[0] = 1'b0; repeat (4) step("R5");
    pin[0] = 1'b1; repeat (10) step("R5");
    // R6: two pins rising together give one request
    pin[1] = 1'b0; pin[12] = 1'b0; latch[12] = 1'b1; repeat (4) step("R6");
    pin[1] = 1'b1; pin[12] = 1'b1; repeat (4) step("R6");
    // R7: clear coinciding with a new set
    pin[2] = 1'b0; repeat (4) step("R7");
    pin[2] = 1'b1; step("R7"); step("R7");
    clr = 16'h0004; step("R7"); clr = '0; repeat (2) step("R7");
    // R8: polarity flip in the cycle the edge arrives
    pin[6] = 1'b0; repeat (4) step("R8");
    pin[6] = 1'b1; step("R8");
    step("R8");
    latch[6] = 1'b0; step("R8"); latch[6] = 1'b1; repeat (3) step("R8");
    // R8: configuration changes on a steady pin
    en0[7] = 1'b0; step("R8"); en0[7] = 1'b1; step("R8");
    latch[7] = ~latch[7]; step("R8"); is_out[7] = 1'b1; step("R8");
    is_out[7] = 1'b0; repeat (3) step("R8");

    // random phase, checked against the model
    for (int n = 0; n < 4000; n++) begin
      pin = pin ^ ($urandom() & $urandom() & $urandom());
      if (($urandom() % 16) == 0) begin
        latch  = latch ^ ($urandom() & $urandom());
        is_out = $urandom() & $urandom() & $urandom();
        en0    = 8'($urandom());
        en1    = 8'($urandom());
      end
      clr = (($urandom() % 8) == 0) ? 16'($urandom()) : '0;
      step("R6");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule